// File: doc/BRIEF.md
# Hot-Plug Slot Power Request Register

This block holds the requested power state for up to six hot-plug slots as one 8-bit register. Each of the low six bits asks for power on one slot. Software writes the register through a plain write port. A separate commit sequencer reads the stored request vector `pwr_req` and drives the slot power pins. That sequencer is outside this block.

Whether a write reaches a bit depends on several conditions. A 3-bit strap sets how many slots are populated, and bits for the other slots cannot be written. A slot whose latch switch is open cannot be written. A slot that is already powered and attached to the bus will not accept a write of 0. A companion slot-enable register can clear any slot here with a one-cycle disable pulse, but nothing in this block writes back to that register.

On read, the bit of every unpopulated slot returns a copy of the highest populated slot's bit. The two top bits always read 0.

Top module: `slot_pwr_en_reg`

## Requirements
- R1: Bit i of the register (i = 0..5) is the power request of slot i. Bit 0 is the first slot. For a populated slot, `rd_data[i]` and `pwr_req[i]` show the stored bit.
- R2: While `rst_n` is low at a clock edge, every stored bit becomes 0, so `rd_data` reads 8'h00 and `pwr_req` is 6'h00.
- R3: A `strap_slots` value of 1 to 6 populates slots 0 to value-1. A value of 0, 7 or anything above 6 populates all six slots.
- R4: The stored bit of an unpopulated slot is held at 0 and ignores writes, so its `pwr_req` bit stays 0.
- R5: On read, each unpopulated slot's bit in `rd_data` equals the `rd_data` bit of the highest populated slot.
- R6: While `latch_open[i]` is 1, a write leaves slot i's bit unchanged.
- R7: While `slot_connected[i]` is 1, a write of 0 to slot i is ignored, and a write of 1 still takes effect.
- R8: A pulse on `se_clear[i]` clears slot i's bit at that clock edge. It wins over a write to the same slot in the same cycle and over the latch and connection rules.
- R9: `rd_data[7:6]` always reads 0, and write data on bits 7:6 has no effect.
- R10: A write presented with `wr_en` high is stored at that clock edge. Its effect is visible on `rd_data` and `pwr_req` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; bit i is the request for slot i |
| rd_data | output | 8 | Read value, with unpopulated slots mirrored |
| strap_slots | input | 3 | Number of populated slots |
| latch_open | input | 6 | Per-slot latch switch open |
| slot_connected | input | 6 | Per-slot powered and connected to the bus |
| se_clear | input | 6 | Per-slot disable pulse from the slot-enable register |
| pwr_req | output | 6 | Stored request bits, passed to the commit sequencer |

## Verification
The write path is exercised with all-ones, all-zeros and alternating data under every strap value from 0 to 7. This separates correct decoding of the populated-slot count from a fixed mask, and shows the readback mirroring the right slot rather than a neighbour. Writes with the latch open and with the slot connected are mixed with writes of both polarities. This separates blocking of all writes from blocking of zero-writes only. Disable pulses are placed alone and in the same cycle as a write of 1, which shows whether the clear wins. Reserved-bit data and reset in the middle of activity round out the patterns.

// File: rtl/slot_pwr_pkg.sv
// Package: shared sizes and types for the slot power request register.
// Assumes at most eight slots, so that a 3-bit strap can count them.
package slot_pwr_pkg;
    localparam int N_SLOTS = 6;
    localparam int REG_W   = 8;
    localparam int STRAP_W = 3;
    localparam int IDX_W   = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

    typedef logic [N_SLOTS-1:0] slot_vec_t;
endpackage

// File: rtl/slot_count_decode.sv
// Turns the slot-count strap into a populated-slot mask and the index of the
// highest populated slot. Zero or out-of-range strap values mean every slot.
// Assumes the strap is quasi-static; the decode is purely combinational.
module slot_count_decode #(
    parameter int N_SLOTS = 6,
    parameter int STRAP_W = 3,
    localparam int IDX_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic [STRAP_W-1:0] strap,
    output logic [N_SLOTS-1:0] en_mask,
    output logic [IDX_W-1:0]   last_idx
);
    int unsigned cnt;

    // Clamp the strap to a count in the range 1..N_SLOTS.
    always_comb begin
        if (strap == '0 || int'(strap) > N_SLOTS) cnt = N_SLOTS;
        else                                      cnt = int'(strap);
    end

    // Build the mask and the top index from the count.
    always_comb begin
        for (int i = 0; i < N_SLOTS; i++) en_mask[i] = (i < int'(cnt));
        last_idx = IDX_W'(cnt - 1);
    end
endmodule

// File: rtl/slot_power_cell.sv
// One slot's stored power request bit, with its write rules. The clear event
// takes priority, then the populated check, then the latch and connection rules.
// Assumes all inputs are synchronous to clk.
module slot_power_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_en,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic latch_open,
    input  logic connected,
    input  logic clr,
    output logic q
);
    // Update the request bit under the slot's write rules.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (clr || !slot_en) begin
            q <= 1'b0;
        end else if (wr_en && !latch_open) begin
            if (wr_bit)          q <= 1'b1;
            else if (!connected) q <= 1'b0;
        end
    end
endmodule

// File: rtl/slot_readback_mux.sv
// Builds the read value. Populated slots show their own bit. Unpopulated slots
// copy the bit of the highest populated slot. Bits above the slots read zero.
// Assumes last_idx always names a populated slot.
module slot_readback_mux #(
    parameter int N_SLOTS = 6,
    parameter int REG_W   = 8,
    localparam int IDX_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic [N_SLOTS-1:0] q,
    input  logic [N_SLOTS-1:0] en_mask,
    input  logic [IDX_W-1:0]   last_idx,
    output logic [REG_W-1:0]   rd_data
);
    // Select, for each slot bit, either its own bit or the mirrored one.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_SLOTS; i++)
            rd_data[i] = en_mask[i] ? q[i] : q[last_idx];
    end
endmodule

// File: rtl/slot_pwr_en_reg.sv
// Top level of the hot-plug slot power request register. It decodes the strap,
// holds one rule-checked cell per slot and mirrors the readback. Assumes the
// companion slot-enable register delivers one-cycle clear pulses per slot.
module slot_pwr_en_reg
    import slot_pwr_pkg::*;
#(
    parameter int NS = N_SLOTS,
    parameter int RW = REG_W,
    parameter int SW = STRAP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_data,
    output logic [RW-1:0] rd_data,
    input  logic [SW-1:0] strap_slots,
    input  logic [NS-1:0] latch_open,
    input  logic [NS-1:0] slot_connected,
    input  logic [NS-1:0] se_clear,
    output logic [NS-1:0] pwr_req
);
    localparam int IW = (NS > 1) ? $clog2(NS) : 1;

    logic [NS-1:0] en_mask;
    logic [IW-1:0] last_idx;
    logic [NS-1:0] q;

    slot_count_decode #(.N_SLOTS(NS), .STRAP_W(SW)) u_decode (
        .strap    (strap_slots),
        .en_mask  (en_mask),
        .last_idx (last_idx)
    );

    for (genvar g = 0; g < NS; g++) begin : g_slot
        slot_power_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .slot_en    (en_mask[g]),
            .wr_en      (wr_en),
            .wr_bit     (wr_data[g]),
            .latch_open (latch_open[g]),
            .connected  (slot_connected[g]),
            .clr        (se_clear[g]),
            .q          (q[g])
        );
    end

    slot_readback_mux #(.N_SLOTS(NS), .REG_W(RW)) u_rdmux (
        .q        (q),
        .en_mask  (en_mask),
        .last_idx (last_idx),
        .rd_data  (rd_data)
    );

    assign pwr_req = q;
endmodule

// File: rtl/slot_pwr_en_chk.sv
// Checker for slot_pwr_en_reg. It watches only the ports and relates them over
// time. It recomputes the populated count from the strap on its own.
module slot_pwr_en_chk #(
    parameter int NS = 6,
    parameter int RW = 8,
    parameter int SW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [RW-1:0] wr_data,
    input logic [RW-1:0] rd_data,
    input logic [SW-1:0] strap_slots,
    input logic [NS-1:0] latch_open,
    input logic [NS-1:0] slot_connected,
    input logic [NS-1:0] se_clear,
    input logic [NS-1:0] pwr_req
);
    int unsigned pop;
    always_comb pop = (strap_slots == '0 || int'(strap_slots) > NS) ? NS : int'(strap_slots);

    // R9: the reserved bits never read 1.
    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[RW-1:NS] == '0);

    for (genvar g = 0; g < NS; g++) begin : g_chk
        // R4: an unpopulated slot's request stays low.
        assert_unpop_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (g >= int'(pop) && $stable(strap_slots)) |=> (pwr_req[g] == 1'b0));
        // R5: an unpopulated slot reads back the top populated slot's bit.
        assert_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (g >= int'(pop)) |-> (rd_data[g] == rd_data[pop-1]));
        // R6: with the latch open and no clear, the bit holds.
        assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (latch_open[g] && !se_clear[g] && g < int'(pop)) |=> (pwr_req[g] == $past(pwr_req[g])));
        // R7: a connected, powered slot cannot drop without a clear.
        assert_conn_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_connected[g] && pwr_req[g] && !se_clear[g] && g < int'(pop)) |=> pwr_req[g]);
        // R8: a disable pulse always lands as a cleared bit.
        assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            se_clear[g] |=> !pwr_req[g]);
    end
endmodule

bind slot_pwr_en_reg slot_pwr_en_chk #(.NS(NS), .RW(RW), .SW(SW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .rd_data        (rd_data),
    .strap_slots    (strap_slots),
    .latch_open     (latch_open),
    .slot_connected (slot_connected),
    .se_clear       (se_clear),
    .pwr_req        (pwr_req)
);

// File: tb/test_slot_pwr_en_reg.sv
// Bench: a behavioural reference model of the request bits, compared with the
// design on every clock. Inputs change at the falling edge. The compare runs
// 3 ns after the rising edge.
module test_slot_pwr_en_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [2:0] strap_slots = 3'd6;
    logic [5:0] latch_open = 6'h00;
    logic [5:0] slot_connected = 6'h00;
    logic [5:0] se_clear = 6'h00;
    logic [5:0] pwr_req;

    int checks = 0;
    int errors = 0;
    string cur_req = "R2";
    bit model [6];
    bit done = 1'b0;

    always #5 clk = ~clk;

    slot_pwr_en_reg i_slot_pwr_en_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .strap_slots(strap_slots), .latch_open(latch_open),
        .slot_connected(slot_connected), .se_clear(se_clear), .pwr_req(pwr_req)
    );

    function automatic int populated(input logic [2:0] s);
        if (s == 0 || s > 6) return 6;   // R3: zero or out of range means all six
        return int'(s);
    endfunction

    // Reference update at each rising edge (R2, R4, R6, R7, R8, R10).
    always @(posedge clk) begin
        int n;
        n = populated(strap_slots);
        for (int i = 0; i < 6; i++) begin
            if (!rst_n)                       model[i] = 0;
            else if (se_clear[i] || i >= n)   model[i] = 0;
            else if (wr_en && !latch_open[i]) begin
                if (wr_data[i])               model[i] = 1;
                else if (!slot_connected[i])  model[i] = 0;
            end
        end
    end

    // Compare the design with the model once per cycle (R1, R5, R9 on reads).
    always @(posedge clk) begin
        #3;
        if (!done) begin
            logic [7:0] exp_rd;
            logic [5:0] exp_pw;
            int n;
            n = populated(strap_slots);
            exp_rd = 8'h00;
            for (int i = 0; i < 6; i++) begin
                exp_pw[i] = model[i];
                exp_rd[i] = (i < n) ? model[i] : model[n-1];
            end
            checks++;
            if (rd_data !== exp_rd) begin
                errors++;
                $display("FAIL %s rd_data actual %h expected %h", cur_req, rd_data, exp_rd);
            end
            checks++;
            if (pwr_req !== exp_pw) begin
                errors++;
                $display("FAIL %s pwr_req actual %h expected %h", cur_req, pwr_req, exp_pw);
            end
        end
    end

    task automatic step(input logic we, input logic [7:0] d, input logic [5:0] clr);
        @(negedge clk);
        wr_en = we; wr_data = d; se_clear = clr;
        @(negedge clk);
        wr_en = 1'b0; se_clear = 6'h00;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset value 00h, checked explicitly as well.
        checks++;
        if (rd_data !== 8'h00 || pwr_req !== 6'h00) begin
            errors++;
            $display("FAIL R2 reset actual %h/%h expected 00/00", rd_data, pwr_req);
        end
        rst_n = 1'b1;

        // R1, R10: plain writes with six slots.
        cur_req = "R1";  step(1, 8'h3F, 0); step(1, 8'h15, 0); step(1, 8'h2A, 0);
        cur_req = "R10"; step(1, 8'h00, 0); step(0, 8'h3F, 0);
        // R9: reserved bits in the data.
        cur_req = "R9";  step(1, 8'hC0, 0); step(1, 8'hFF, 0);

        // R3, R4, R5: each strap value.
        for (int s = 0; s < 8; s++) begin
            @(negedge clk); strap_slots = 3'(s);
            cur_req = (s == 0 || s == 7) ? "R3" : "R5";
            step(1, 8'h00, 0); step(1, 8'hFF, 0);
            cur_req = "R4";  step(1, 8'h15, 0); step(1, 8'h2A, 0);
        end
        @(negedge clk); strap_slots = 3'd6;

        // R6: latch open on alternating slots.
        cur_req = "R6";
        step(1, 8'h3F, 0);
        @(negedge clk); latch_open = 6'h15;
        step(1, 8'h00, 0); step(1, 8'h3F, 0); step(1, 8'h00, 0);
        @(negedge clk); latch_open = 6'h00;

        // R7: connected slots refuse zero, still take one.
        cur_req = "R7";
        step(1, 8'h00, 0);
        @(negedge clk); slot_connected = 6'h0F;
        step(1, 8'h3F, 0); step(1, 8'h00, 0); step(1, 8'h30, 0);

        // R8: clears, alone and against writes of 1, with latch and connection set.
        cur_req = "R8";
        step(0, 8'h00, 6'h03);
        step(1, 8'h3F, 6'h0C);
        @(negedge clk); latch_open = 6'h30;
        step(0, 8'h00, 6'h30);
        @(negedge clk); latch_open = 6'h00; slot_connected = 6'h00;

        // R2: reset in the middle of activity.
        cur_req = "R2";
        step(1, 8'h3F, 0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        step(0, 8'h00, 0);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule